// File: doc/BRIEF.md
# Write-Leveling Calibration Sequencer

This block is a hardware sequencer that aligns the data strobe of four memory byte lanes with the memory clock. A start request launches a coarse pass. In that pass every lane's strobe delay is stepped through the eight octants of a clock period, and the feedback level each lane returns is recorded. The eight recorded levels are treated as a ring. The lowest octant whose sample is low and whose circular successor is high becomes that lane's base. A fine pass then walks each healthy lane through 1/256-period steps above its base and keeps the largest delay that still lands ahead of the rising clock edge.

Each lane's result is a delay in 1/256-period units, reported as a half-period flag plus a 7-bit remainder. When a result reaches a full period it wraps to zero. An optional clamp replaces any result above 200/256 with zero, because a strobe that late is already within tolerance of the previous edge. A lane whose eight coarse samples are all the same level is flagged in error, sits at zero delay during the fine pass and reports zero. The physical delay line and the memory device sit outside the block. The delay line is quantised to roughly 156 elements per period, so neighbouring 1/256 codes can give the same physical delay.

Control and status are plain pins. There is no streaming data path, so there is no valid/ready handshake. The feedback inputs are sampled only at the end of each settle window.

Top module: `wl_cal_seq`

## Requirements
- R1: A high `ctl_start` sampled while idle launches a run, and `wl_status[0]` (busy) is high from the next cycle until the block returns to idle. A `ctl_start` sampled while busy is ignored.
- R2: The coarse pass drives every lane to delay o*32 for o = 0 to 7 in ascending order. Each step is held for `settle_cycles`+1 cycles, and the feedback is sampled in the last of those cycles.
- R3: A lane is in error when its eight coarse samples are all low or all high. Error bits are reported on `wl_status[8+lane]` and are cleared when a run starts.
- R4: The base octant is the lowest o with sample[o] low and sample[(o+1) mod 8] high, where octant 7 is followed by octant 0.
- R5: After one analysis cycle, the fine pass drives each healthy lane to base*32+s for s = 1 to 31. Each step is held `settle_cycles`+1 cycles. Lanes in error are driven to 0. When every lane is in error, the fine pass is skipped.
- R6: A lane's result is one less than the first fine delay that samples high. If no fine step samples high, the result is (base+1)*32 mod 256, so a full period wraps to 0.
- R7: Lane l reports result bit 7 on `res_half[l]` and bits 6:0 on `res_offset[7l+6:7l]`. A lane in error reports 0. Results change only in the cycle in which busy falls.
- R8: When `ctl_clamp` is high, a result above 200 is reported as 0. A result of 200 or less is left unchanged.
- R9: `wl_status[1]` (done) is set when a run completes and cleared when the next run starts. `wl_status[7:2]` always read 0.
- R10: While idle, every lane delay output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Start request, sampled while idle |
| ctl_clamp | input | 1 | Zero results above 200/256; hold stable during a run |
| settle_cycles | input | 8 | Extra wait cycles after each delay change; hold stable during a run |
| lane_fb | input | 4 | Per-lane feedback level: high means the clock is high at the strobe edge |
| lane_dly | output | 32 | Per-lane delay code in 1/256 period units, lane l at bits 8l+7:8l |
| wl_status | output | 12 | Bit 0 busy, bit 1 done, bits 7:2 zero, bits 11:8 lane error |
| res_half | output | 4 | Per-lane half-period flag of the result |
| res_offset | output | 28 | Per-lane 7-bit remainder of the result, lane l at bits 7l+6:7l |

## Verification
Two events can fall in the same cycle. The first is a new start request arriving in the finishing cycle, the cycle in which results are latched. The second is the final fine step, where a lane's first high sample coincides with the end of the sweep. The bench raises `ctl_start` exactly in the finishing cycle and again in the middle of a run. It also places lane edges so that a first high lands on the last fine step or on no fine step at all. A behavioural reference predicts busy, done and every lane delay cycle by cycle, and it predicts the final results. The bench requires that the extra start requests neither restart nor disturb the run, and that the wrapped and clamped results come out as the requirements state.

// File: rtl/wl_cal_pkg.sv
package wl_cal_pkg;
  typedef enum logic [1:0] {
    WL_IDLE = 2'd0,
    WL_WAIT = 2'd1,
    WL_PICK = 2'd2,
    WL_DONE = 2'd3
  } wl_state_e;

  typedef enum logic {
    PH_COARSE = 1'b0,
    PH_FINE   = 1'b1
  } wl_phase_e;
endpackage

// File: rtl/wl_settle_timer.sv
module wl_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/wl_octant_pick.sv
module wl_octant_pick #(
  parameter int OCT = 8,
  localparam int OW = $clog2(OCT)
) (
  input  logic [OCT-1:0] samples,
  output logic [OW-1:0]  base,
  output logic           err
);
  logic found;

  // Scan downward so the lowest rising position wins.
  always_comb begin
    base  = '0;
    found = 1'b0;
    for (int o = OCT - 1; o >= 0; o--) begin
      if (!samples[o] && samples[(o + 1) % OCT]) begin
        base  = OW'(o);
        found = 1'b1;
      end
    end
    err = !found;
  end
endmodule

// File: rtl/wl_lane_fine.sv
module wl_lane_fine #(
  parameter int DLY_W     = 8,
  parameter int OW        = 3,
  parameter int STEP      = 32,
  parameter int CLAMP_LIM = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_en,
  input  logic             fb,
  input  logic [DLY_W-1:0] dly_now,
  input  logic [OW-1:0]    base,
  input  logic             lane_err,
  input  logic             clamp_en,
  output logic [DLY_W-1:0] final_dly
);
  logic             hit_q;
  logic [DLY_W-1:0] last_low_q;
  logic [DLY_W-1:0] bound;
  logic [DLY_W-1:0] raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q      <= 1'b0;
      last_low_q <= '0;
    end else if (clear) begin
      hit_q      <= 1'b0;
    end else if (sample_en && !hit_q && fb) begin
      hit_q      <= 1'b1;
      last_low_q <= dly_now - 1'b1;
    end
  end

  // Next octant boundary, modulo one period.
  assign bound = DLY_W'((int'(base) + 1) * STEP);

  always_comb begin
    if (lane_err)   raw = '0;
    else if (hit_q) raw = last_low_q;
    else            raw = bound;
    final_dly = (clamp_en && (int'(raw) > CLAMP_LIM)) ? '0 : raw;
  end
endmodule

// File: rtl/wl_cal_seq.sv
module wl_cal_seq #(
  parameter int LANES     = 4,
  parameter int OCT       = 8,
  parameter int DLY_W     = 8,
  parameter int SETTLE_W  = 8,
  parameter int CLAMP_LIM = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_start,
  input  logic                     ctl_clamp,
  input  logic [SETTLE_W-1:0]      settle_cycles,
  input  logic [LANES-1:0]         lane_fb,
  output logic [LANES*DLY_W-1:0]   lane_dly,
  output logic [LANES+7:0]         wl_status,
  output logic [LANES-1:0]         res_half,
  output logic [LANES*(DLY_W-1)-1:0] res_offset
);
  import wl_cal_pkg::*;

  localparam int STEP  = (1 << DLY_W) / OCT;
  localparam int OW    = $clog2(OCT);
  localparam int SW    = $clog2(STEP) + 1;
  localparam int OFF_W = DLY_W - 1;

  wl_state_e        state_q;
  wl_phase_e        phase_q;
  logic [SW-1:0]    step_q;
  logic [OCT-1:0]   smp_q   [LANES];
  logic [OW-1:0]    base_q  [LANES];
  logic [LANES-1:0] err_q;
  logic             done_q;
  logic [DLY_W-1:0] res_q   [LANES];

  logic [OW-1:0]    pick_base [LANES];
  logic [LANES-1:0] pick_err;
  logic [DLY_W-1:0] lane_final [LANES];
  logic [DLY_W-1:0] dly_l      [LANES];

  logic expired, timer_load, smp_ev, last_step, start_acc;

  assign start_acc  = (state_q == WL_IDLE) && ctl_start;
  assign smp_ev     = (state_q == WL_WAIT) && expired;
  assign last_step  = (phase_q == PH_COARSE) ? (step_q == SW'(OCT - 1))
                                             : (step_q == SW'(STEP - 1));
  assign timer_load = start_acc || (smp_ev && !last_step) || (state_q == WL_PICK);

  wl_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (settle_cycles),
    .expired  (expired)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wl_octant_pick #(.OCT(OCT)) u_pick (
      .samples (smp_q[l]),
      .base    (pick_base[l]),
      .err     (pick_err[l])
    );

    always_comb begin
      dly_l[l] = '0;
      if (state_q == WL_WAIT) begin
        if (phase_q == PH_COARSE)
          dly_l[l] = DLY_W'(int'(step_q) * STEP);
        else if (!err_q[l])
          dly_l[l] = DLY_W'(int'(base_q[l]) * STEP + int'(step_q));
      end
    end

    wl_lane_fine #(
      .DLY_W(DLY_W), .OW(OW), .STEP(STEP), .CLAMP_LIM(CLAMP_LIM)
    ) u_fine (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q == WL_PICK),
      .sample_en (smp_ev && (phase_q == PH_FINE)),
      .fb        (lane_fb[l]),
      .dly_now   (dly_l[l]),
      .base      (base_q[l]),
      .lane_err  (err_q[l]),
      .clamp_en  (ctl_clamp),
      .final_dly (lane_final[l])
    );

    assign lane_dly[l*DLY_W +: DLY_W]   = dly_l[l];
    assign res_half[l]                  = res_q[l][DLY_W-1];
    assign res_offset[l*OFF_W +: OFF_W] = res_q[l][OFF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WL_IDLE;
      phase_q <= PH_COARSE;
      step_q  <= '0;
      err_q   <= '0;
      done_q  <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        smp_q[l]  <= '0;
        base_q[l] <= '0;
        res_q[l]  <= '0;
      end
    end else begin
      unique case (state_q)
        WL_IDLE: if (ctl_start) begin
          state_q <= WL_WAIT;
          phase_q <= PH_COARSE;
          step_q  <= '0;
          err_q   <= '0;
          done_q  <= 1'b0;
        end
        WL_WAIT: if (expired) begin
          if (phase_q == PH_COARSE)
            for (int l = 0; l < LANES; l++)
              smp_q[l][step_q[OW-1:0]] <= lane_fb[l];
          if (last_step)
            state_q <= (phase_q == PH_COARSE) ? WL_PICK : WL_DONE;
          else
            step_q <= step_q + 1'b1;
        end
        WL_PICK: begin
          for (int l = 0; l < LANES; l++) base_q[l] <= pick_base[l];
          err_q <= pick_err;
          if (&pick_err) begin
            state_q <= WL_DONE;
          end else begin
            state_q <= WL_WAIT;
            phase_q <= PH_FINE;
            step_q  <= SW'(1);
          end
        end
        WL_DONE: begin
          for (int l = 0; l < LANES; l++) res_q[l] <= lane_final[l];
          done_q  <= 1'b1;
          state_q <= WL_IDLE;
        end
        default: state_q <= WL_IDLE;
      endcase
    end
  end

  assign wl_status = {err_q, 6'b0, done_q, (state_q != WL_IDLE)};
endmodule

// File: rtl/wl_cal_chk.sv
module wl_cal_chk #(
  parameter int LANES     = 4,
  parameter int DLY_W     = 8,
  parameter int CLAMP_LIM = 200
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ctl_start,
  input logic                       ctl_clamp,
  input logic [LANES*DLY_W-1:0]     lane_dly,
  input logic [LANES+7:0]           wl_status,
  input logic [LANES-1:0]           res_half,
  input logic [LANES*(DLY_W-1)-1:0] res_offset
);
  localparam int OFF_W = DLY_W - 1;
  logic busy;
  assign busy = wl_status[0];

  // R1
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_start) |=> busy);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctl_start) |=> !wl_status[1]);

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wl_status[7:2] == 6'b0);

  // R10
  idle_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_dly == '0));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable({res_half, res_offset}));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R8
    clamp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && $past(ctl_clamp))
        |-> (int'({res_half[l], res_offset[l*OFF_W +: OFF_W]}) <= CLAMP_LIM));
  end
endmodule

bind wl_cal_seq wl_cal_chk #(
  .LANES(LANES), .DLY_W(DLY_W), .CLAMP_LIM(CLAMP_LIM)
) u_wl_cal_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_start  (ctl_start),
  .ctl_clamp  (ctl_clamp),
  .lane_dly   (lane_dly),
  .wl_status  (wl_status),
  .res_half   (res_half),
  .res_offset (res_offset)
);

// File: tb/test_wl_cal_seq.sv
module test_wl_cal_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_start = 1'b0;
  logic        ctl_clamp = 1'b0;
  logic [7:0]  settle_cycles = 8'd0;
  logic [3:0]  lane_fb;
  logic [31:0] lane_dly;
  logic [11:0] wl_status;
  logic [3:0]  res_half;
  logic [27:0] res_offset;

  int checks = 0;
  int errors = 0;

  // Device model: per-lane clock edge position and stuck mode (0 live, 1 high, 2 low).
  int edge_pos [4];
  int mode     [4];

  // Reference expectations.
  int  exp_res  [4];
  int  exp_base [4];
  bit  exp_err  [4];
  bit  all_err;
  int  S;
  int  fend;
  int  k;
  bit  mrun = 0;
  bit  ran_once = 0;

  always #4 clk = ~clk;

  wl_cal_seq i_wl_cal_seq (
    .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_clamp(ctl_clamp),
    .settle_cycles(settle_cycles), .lane_fb(lane_fb), .lane_dly(lane_dly),
    .wl_status(wl_status), .res_half(res_half), .res_offset(res_offset)
  );

  function automatic int quant(int d);
    return (((d * 156) / 256) * 256) / 156;
  endfunction

  function automatic bit fbm(int l, int d);
    int diff;
    if (mode[l] == 1) return 1'b1;
    if (mode[l] == 2) return 1'b0;
    diff = ((quant(d) - edge_pos[l]) % 256 + 256) % 256;
    return diff < 128;
  endfunction

  always_comb
    for (int l = 0; l < 4; l++) lane_fb[l] = fbm(l, int'(lane_dly[l*8 +: 8]));

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic plan_run(int s_val, bit clamp);
    bit c [8];
    S = s_val;
    all_err = 1'b1;
    for (int l = 0; l < 4; l++) begin
      int r;
      bit found;
      found = 1'b0;
      exp_base[l] = 0;
      for (int o = 0; o < 8; o++) c[o] = fbm(l, o * 32);
      for (int o = 0; o < 8; o++)
        if (!found && !c[o] && c[(o + 1) % 8]) begin found = 1'b1; exp_base[l] = o; end
      exp_err[l] = !found;
      r = -1;
      if (found) begin
        all_err = 1'b0;
        for (int s = 1; s < 32; s++)
          if (r < 0 && fbm(l, exp_base[l] * 32 + s)) r = exp_base[l] * 32 + s - 1;
        if (r < 0) r = (exp_base[l] * 32 + 32) % 256;
      end else r = 0;
      if (clamp && r > 200) r = 0;
      exp_res[l] = r;
    end
    fend = all_err ? 8 * (S + 1) + 1 : 39 * (S + 1) + 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) mrun = 0;
    else if (mrun) begin
      if (k == fend) begin mrun = 0; ran_once = 1; end
      else k++;
    end else if (ctl_start) begin
      mrun = 1;
      k = 0;
    end
  end

  function automatic int exp_dly(int l);
    int c0;
    if (!mrun) return 0;
    c0 = 8 * (S + 1);
    if (k < c0) return (k / (S + 1)) * 32;
    if (k == c0 || k >= fend) return 0;
    if (exp_err[l]) return 0;
    return exp_base[l] * 32 + 1 + (k - c0 - 1) / (S + 1);
  endfunction

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) if (rst_n) begin
    check(mrun ? "R1" : "R10", int'(wl_status[0]), int'(mrun), "busy");
    check("R9", int'(wl_status[1]), int'(!mrun && ran_once), "done");
    check("R9", int'(wl_status[7:2]), 0, "reserved status");
    for (int l = 0; l < 4; l++)
      check(mrun ? ((k <= 8 * (S + 1)) ? "R2" : "R5") : "R10",
            int'(lane_dly[l*8 +: 8]), exp_dly(l), $sformatf("lane %0d delay", l));
  end

  task automatic check_results(string tag);
    for (int l = 0; l < 4; l++) begin
      check("R3", int'(wl_status[8 + l]), int'(exp_err[l]), $sformatf("%s lane %0d error", tag, l));
      check("R7", int'({res_half[l], res_offset[l*7 +: 7]}), exp_res[l],
            $sformatf("%s lane %0d result (R4 R6 R8)", tag, l));
    end
  endtask

  // poke: 1 = extra start mid-run, 2 = extra start in the finishing cycle
  task automatic run(string tag, int s_val, bit clamp, int poke);
    settle_cycles = 8'(s_val);
    ctl_clamp = clamp;
    plan_run(s_val, clamp);
    @(negedge clk); ctl_start = 1'b1;
    @(negedge clk); ctl_start = 1'b0;
    if (poke == 1) begin
      repeat (20) @(negedge clk);
      ctl_start = 1'b1;
      @(negedge clk); ctl_start = 1'b0;
    end else if (poke == 2) begin
      while (!(mrun && k == fend)) @(negedge clk);
      ctl_start = 1'b1;
      @(negedge clk); ctl_start = 1'b0;
    end
    while (mrun) @(negedge clk);
    @(negedge clk);
    check_results(tag);
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin edge_pos[l] = 0; mode[l] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(wl_status), 0, "reset status");
    check("R7", int'({res_half, res_offset}), 0, "reset results");

    // Live lanes, no clamp: a result above 200 is kept.
    edge_pos = '{10, 100, 230, 60};
    run("A", 0, 1'b0, 0);

    // Same lanes with clamp, extra start mid-run.
    run("B", 2, 1'b1, 1);

    // Wraparound lane, clamped lane, stuck-high and stuck-low lanes; start in final cycle.
    edge_pos = '{0, 205, 0, 0};
    mode = '{0, 0, 1, 2};
    run("C", 3, 1'b1, 2);

    // Every lane in error: fine pass skipped.
    mode = '{1, 2, 1, 2};
    run("D", 1, 1'b0, 0);

    // Edges near octant boundaries.
    mode = '{0, 0, 0, 0};
    edge_pos = '{31, 32, 33, 128};
    run("E", 0, 1'b0, 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule